// File: doc/BRIEF.md
# Host-Write Line Invalidate Tracker

When the host writes straight into device memory, the write goes around the compute-side caches. A line those caches hold may then be stale. This block watches the host write port. For every write that falls inside the device-memory window, it issues an invalidate for the affected cache line to each compute unit's path toward the shared L2 cache, one compute unit per cycle. Each compute unit returns one acknowledge for each invalidate it receives. The block keeps a single count of invalidates that are issued but not yet acknowledged.

The command processor raises a launch request before it starts the next kernel. The block grants that request only after the issue sequencer is idle and the count has reached zero. The grant lasts one cycle. Host writes are expected only between kernels, so the targeted lines are never dirty and an invalidate never has to write data back.

The issue sequencer has two states. `ISS_IDLE` accepts a write. The transition ISS_IDLE to ISS_SEND is taken on an accepted write inside the window. `ISS_SEND` presents the invalidate to one compute unit per cycle. The transition ISS_SEND to ISS_IDLE is taken after the last compute unit. The launch gate also has two states. `GATE_OPEN` may grant. The transition GATE_OPEN to GATE_HELD is taken on a grant. `GATE_HELD` waits for the request to drop. The transition GATE_HELD to GATE_OPEN is taken when the request is low.

Top module: `hwinv_tracker`

## Requirements
- R1: A write accepted inside the window [APER_BASE, APER_LAST] is followed by NUM_CU invalidate cycles. Starting in the cycle after acceptance, `inv_valid` is one-hot with bit 0 first, then bit 1, and so on up to bit NUM_CU-1, one bit per cycle. After that `inv_valid` returns to zero.
- R2: While any bit of `inv_valid` is high, `inv_addr` equals the accepted write address with its low log2(LINE_BYTES) bits forced to zero. LINE_BYTES is a power of two and defaults to 64.
- R3: A write accepted outside the window produces no invalidate and leaves `busy` low.
- R4: The outstanding count rises by one for each invalidate cycle. It falls by the number of `inv_ack` bits that are high in a cycle. When one invalidate and one acknowledge fall in the same cycle, the count is unchanged.
- R5: `launch_grant` stays low while the outstanding count is nonzero or invalidates are still being issued. It goes high in the first cycle in which `launch_req` is high and both conditions are clear.
- R6: `launch_grant` is a one-cycle pulse. A further grant requires `launch_req` to go low first.
- R7: `host_wr_ready` is low while invalidates are being issued. It is also low while the count exceeds 2^CNT_W-1-NUM_CU, so the counter can never overflow.
- R8: `host_wr_ready` is low while `launch_req` is high.
- R9: `busy` is high exactly when invalidates are being issued or the outstanding count is nonzero.
- R10: After reset, `inv_valid` and `launch_grant` are zero, `busy` is low and `host_wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_valid | input | 1 | Host write present |
| host_wr_addr | input | ADDR_W | Host write byte address |
| host_wr_ready | output | 1 | Host write accepted this cycle when valid is high |
| inv_valid | output | NUM_CU | Invalidate request, one bit per compute unit |
| inv_addr | output | ADDR_W | Line-aligned invalidate address |
| inv_ack | input | NUM_CU | Invalidate completion, one bit per compute unit |
| launch_req | input | 1 | Kernel launch request |
| launch_grant | output | 1 | One-cycle launch permission |
| busy | output | 1 | Invalidates issuing or outstanding |

## Verification
Every cycle, the assertions check the following: `inv_valid` is one-hot or zero, `inv_addr` is line-aligned, the compute-unit index steps in order, the counter neither overflows nor underflows, the grant lasts one cycle, and the host port is never ready while invalidates are issuing. Only the directed scenarios can show the rest. These cover the exact cycle in which the grant appears after the last acknowledge, the count staying unchanged when an issue and an acknowledge coincide, the out-of-window case, and the threshold at which back-pressure starts and ends.

// File: rtl/hwinv_pkg.sv
package hwinv_pkg;
    typedef enum logic {
        ISS_IDLE = 1'b0,
        ISS_SEND = 1'b1
    } iss_state_e;

    typedef enum logic {
        GATE_OPEN = 1'b0,
        GATE_HELD = 1'b1
    } gate_state_e;
endpackage

// File: rtl/hwinv_outstanding.sv
module hwinv_outstanding #(
    parameter int NUM_CU = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [NUM_CU-1:0] ack,
    output logic              room,
    output logic              zero
);
    localparam int MAXV  = (1 << CNT_W) - 1;
    localparam int LIMIT = MAXV - NUM_CU;
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] count_q;
    logic [SUM_W-1:0] ack_sum;
    logic [SUM_W-1:0] next_sum;

    always_comb begin
        ack_sum = '0;
        for (int i = 0; i < NUM_CU; i++) begin
            ack_sum = ack_sum + SUM_W'(ack[i]);
        end
        next_sum = SUM_W'(count_q) + SUM_W'(issue) - ack_sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= next_sum[CNT_W-1:0];
        end
    end

    assign room = (SUM_W'(count_q) <= SUM_W'(LIMIT));
    assign zero = (count_q == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && (SUM_W'(count_q) == SUM_W'(MAXV)) && (ack == '0))); // R7

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ack_sum <= SUM_W'(count_q) + SUM_W'(issue)); // R4
endmodule

// File: rtl/hwinv_issue_fsm.sv
module hwinv_issue_fsm
    import hwinv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_CU     = 4,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              in_window,
    input  logic              admit,
    output logic              wr_ready,
    output logic [NUM_CU-1:0] inv_valid,
    output logic [ADDR_W-1:0] inv_addr,
    output logic              issuing,
    output logic              issue_pulse
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = (NUM_CU > 1) ? $clog2(NUM_CU) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CU - 1);

    iss_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [ADDR_W-1:0] line_q, line_d;
    logic              take;

    assign wr_ready = (state_q == ISS_IDLE) && admit;
    assign take     = wr_valid && wr_ready && in_window;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        line_d  = line_q;
        unique case (state_q)
            ISS_IDLE: begin
                if (take) begin
                    state_d = ISS_SEND;
                    idx_d   = '0;
                    line_d  = {wr_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                end
            end
            ISS_SEND: begin
                if (idx_q == LAST_IDX) begin
                    state_d = ISS_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ISS_IDLE;
            idx_q   <= '0;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            line_q  <= line_d;
        end
    end

    for (genvar g = 0; g < NUM_CU; g++) begin : g_cu
        assign inv_valid[g] = (state_q == ISS_SEND) && (idx_q == IDX_W'(g));
    end

    assign inv_addr    = line_q;
    assign issuing     = (state_q == ISS_SEND);
    assign issue_pulse = (state_q == ISS_SEND);

    AST_ISSUE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ISS_SEND && idx_q != LAST_IDX) |=> (idx_q == $past(idx_q) + 1'b1)); // R1

    AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (|inv_valid) |-> (inv_addr[OFF_W-1:0] == '0)); // R2
endmodule

// File: rtl/hwinv_launch_gate.sv
module hwinv_launch_gate
    import hwinv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch_req,
    input  logic drained,
    output logic launch_grant
);
    gate_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN: if (launch_req && drained) state_d = GATE_HELD;
            GATE_HELD: if (!launch_req)           state_d = GATE_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        launch_grant = 1'b0;
        unique case (state_q)
            GATE_OPEN: launch_grant = launch_req && drained;
            GATE_HELD: launch_grant = 1'b0;
        endcase
    end

    AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        launch_grant |=> !launch_grant); // R6
endmodule

// File: rtl/hwinv_tracker.sv
module hwinv_tracker #(
    parameter int          ADDR_W     = 32,
    parameter int          NUM_CU     = 4,
    parameter int          LINE_BYTES = 64,
    parameter int          CNT_W      = 4,
    parameter logic [31:0] APER_BASE  = 32'h1000_0000,
    parameter logic [31:0] APER_LAST  = 32'h1FFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_valid,
    input  logic [ADDR_W-1:0] host_wr_addr,
    output logic              host_wr_ready,
    output logic [NUM_CU-1:0] inv_valid,
    output logic [ADDR_W-1:0] inv_addr,
    input  logic [NUM_CU-1:0] inv_ack,
    input  logic              launch_req,
    output logic              launch_grant,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(APER_BASE);
    localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(APER_LAST);

    logic in_window, room, zero, issuing, issue_pulse, drained;

    assign in_window = (host_wr_addr >= WIN_LO) && (host_wr_addr <= WIN_HI);

    hwinv_issue_fsm #(
        .ADDR_W(ADDR_W), .NUM_CU(NUM_CU), .LINE_BYTES(LINE_BYTES)
    ) u_issue (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(host_wr_valid), .wr_addr(host_wr_addr),
        .in_window(in_window), .admit(room && !launch_req),
        .wr_ready(host_wr_ready),
        .inv_valid(inv_valid), .inv_addr(inv_addr),
        .issuing(issuing), .issue_pulse(issue_pulse)
    );

    hwinv_outstanding #(
        .NUM_CU(NUM_CU), .CNT_W(CNT_W)
    ) u_count (
        .clk(clk), .rst_n(rst_n),
        .issue(issue_pulse), .ack(inv_ack),
        .room(room), .zero(zero)
    );

    assign drained = zero && !issuing;
    assign busy    = !drained;

    hwinv_launch_gate u_gate (
        .clk(clk), .rst_n(rst_n),
        .launch_req(launch_req), .drained(drained),
        .launch_grant(launch_grant)
    );

    AST_INV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inv_valid)); // R1

    AST_NO_READY_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (|inv_valid) |-> !host_wr_ready); // R7

    AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        launch_grant |-> (inv_valid == '0)); // R5

    AST_LAUNCH_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        launch_req |-> !host_wr_ready); // R8
endmodule

// File: tb/tb_hwinv_tracker.sv
module tb_hwinv_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int NCU = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr_valid = 1'b0;
    logic [31:0] host_wr_addr = '0;
    logic host_wr_ready;
    logic [NCU-1:0] inv_valid;
    logic [31:0] inv_addr;
    logic [NCU-1:0] inv_ack = '0;
    logic launch_req = 1'b0;
    logic launch_grant;
    logic busy;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hwinv_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_valid(host_wr_valid), .host_wr_addr(host_wr_addr),
        .host_wr_ready(host_wr_ready),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ack(inv_ack),
        .launch_req(launch_req), .launch_grant(launch_grant), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive a write; when expect_inv is set, check the full per-CU sequence.
    task automatic do_write(input logic [31:0] addr, input bit expect_inv);
        @(negedge clk);
        host_wr_valid = 1'b1;
        host_wr_addr  = addr;
        #1 chk("R7 ready before write", {31'd0, host_wr_ready}, 32'd1);
        @(negedge clk);
        host_wr_valid = 1'b0;
        if (expect_inv) begin
            for (int i = 0; i < NCU; i++) begin
                #1;
                chk("R1 inv_valid order", {28'd0, inv_valid}, 32'(1 << i));
                chk("R2 inv_addr aligned", inv_addr, addr & 32'hFFFF_FFC0);
                chk("R9 busy while issuing", {31'd0, busy}, 32'd1);
                chk("R7 ready low while issuing", {31'd0, host_wr_ready}, 32'd0);
                @(negedge clk);
            end
            #1 chk("R1 inv_valid idle after sequence", {28'd0, inv_valid}, 32'd0);
        end else begin
            #1;
            chk("R3 no invalidate outside window", {28'd0, inv_valid}, 32'd0);
            chk("R3 busy stays low", {31'd0, busy}, 32'd0);
        end
    endtask

    task automatic pulse_ack(input logic [NCU-1:0] m);
        @(negedge clk);
        inv_ack = m;
        @(negedge clk);
        inv_ack = '0;
    endtask

    task automatic t_reset;
        #1;
        chk("R10 inv_valid reset", {28'd0, inv_valid}, 32'd0);
        chk("R10 grant reset", {31'd0, launch_grant}, 32'd0);
        chk("R10 busy reset", {31'd0, busy}, 32'd0);
        chk("R10 ready reset", {31'd0, host_wr_ready}, 32'd1);
    endtask

    task automatic t_outside;
        do_write(32'h0000_1234, 1'b0);
        do_write(32'h2000_0000, 1'b0);
    endtask

    task automatic t_gate;
        do_write(32'h1000_0ABC, 1'b1);
        launch_req = 1'b1;
        #1 chk("R5 no grant while outstanding", {31'd0, launch_grant}, 32'd0);
        chk("R8 ready low with launch pending", {31'd0, host_wr_ready}, 32'd0);
        pulse_ack(4'b0001);
        pulse_ack(4'b0010);
        pulse_ack(4'b0100);
        #1 chk("R5 no grant with one left", {31'd0, launch_grant}, 32'd0);
        chk("R9 busy with one left", {31'd0, busy}, 32'd1);
        @(negedge clk);
        inv_ack = 4'b1000;
        #1 chk("R5 no grant in ack cycle", {31'd0, launch_grant}, 32'd0);
        @(negedge clk);
        inv_ack = '0;
        #1 chk("R5 grant after last ack", {31'd0, launch_grant}, 32'd1);
        chk("R9 busy low when drained", {31'd0, busy}, 32'd0);
        @(negedge clk);
        #1 chk("R6 grant one cycle", {31'd0, launch_grant}, 32'd0);
        launch_req = 1'b0;
        @(negedge clk);
        launch_req = 1'b1;
        #1 chk("R6 regrant after drop", {31'd0, launch_grant}, 32'd1);
        @(negedge clk);
        launch_req = 1'b0;
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        host_wr_valid = 1'b1;
        host_wr_addr  = 32'h1234_5678;
        @(negedge clk);
        host_wr_valid = 1'b0;
        @(negedge clk);
        inv_ack = 4'b0001;
        #1 chk("R1 second CU issuing", {28'd0, inv_valid}, 32'd2);
        @(negedge clk);
        inv_ack = '0;
        @(negedge clk);
        @(negedge clk);
        launch_req = 1'b1;
        #1 chk("R4 three still outstanding", {31'd0, launch_grant}, 32'd0);
        @(negedge clk);
        inv_ack = 4'b1110;
        @(negedge clk);
        inv_ack = '0;
        #1 chk("R4 multi-ack drains count", {31'd0, launch_grant}, 32'd1);
        @(negedge clk);
        launch_req = 1'b0;
    endtask

    task automatic t_backpressure;
        do_write(32'h1000_0040, 1'b1);
        do_write(32'h1000_0080, 1'b1);
        do_write(32'h1000_00C0, 1'b1);
        @(negedge clk);
        host_wr_valid = 1'b1;
        host_wr_addr  = 32'h1000_0100;
        #1 chk("R7 ready low at count 12", {31'd0, host_wr_ready}, 32'd0);
        @(negedge clk);
        #1 chk("R7 write held, no invalidate", {28'd0, inv_valid}, 32'd0);
        host_wr_valid = 1'b0;
        pulse_ack(4'b1111);
        #1 chk("R7 ready back at count 8", {31'd0, host_wr_ready}, 32'd1);
        pulse_ack(4'b1111);
        pulse_ack(4'b1111);
        #1 chk("R9 idle after full drain", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_outside();
        t_gate();
        t_same_cycle();
        t_backpressure();
        finished = 1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule